// File: doc/BRIEF.md
# Oscillator Tuning-Word Encoder with Sigma-Delta and Pseudo-Random Dither

This block turns a fixed-point frequency tuning word, produced by a digital loop filter, into the two control codes that set a switched-capacitor oscillator. The whole part of the word selects a coarse capacitor bank for range and is passed out as a plain binary code. The upper fractional part selects a fine bank whose elements are enabled one after another, so the fine output is a thermometer code and every step up adds capacitance. The lowest bits cannot be built as capacitors. A first-order sigma-delta modulator clocked faster than the loop updates realizes them instead: it moves the fine code between two adjacent values so that the average frequency falls between codes.

A pseudo-random dither can be added on top of the modulator to break the repeating patterns that cause limit cycles. Its source is a maximal-length shift register and its amplitude is selectable. The fine code never crosses into the coarse bank. It clips at the ends of its range, so a coarse step cannot be triggered by modulation. A new tuning word takes effect only when a load strobe is given. Both bank outputs come from flops so that all switch controls change on the same clock edge.

Top module: `dco_tune_encoder`

## Requirements
- R1: While rstN is low, coarseCode and fineTherm are all zero. After reset the held word is zero, the modulator accumulator is zero and the dither register holds 1.
- R2: The word on tuneWord is captured only at a clock edge where loadStb is 1. The outputs at the following edge are the first to use it, and with loadStb at 0 the outputs keep following the previously captured word.
- R3: tuneWord[15:10] is the coarse field, and coarseCode equals the coarse field of the held word as an unsigned binary number.
- R4: tuneWord[9:5] is the fine field. fineTherm carries N ones in bits [N-1:0] and zeros above them for a fine output value N from 0 to 31.
- R5: tuneWord[4:0] is the fraction. Each clock it is added into a 5-bit accumulator, and a carry out of that addition raises the fine output by one for that clock. Over any 32 consecutive clocks with a fixed held word and no dither, exactly fraction-many clocks are raised.
- R6: With a zero fraction and no dither, the fine output equals the fine field every clock.
- R7: The dither source is a 15-bit register that shifts left every clock and takes bit14 XOR bit13 into bit0, which gives a maximal-length sequence for x^15+x^14+1. When ditherEn and ditherAmp are both 1, bit0 before the shift adds one more fine step.
- R8: When ditherEn or ditherAmp is 0, the dither adds nothing.
- R9: The fine output saturates at 31 after carry and dither are added, and it never changes coarseCode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Modulator and register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| loadStb | input | 1 | Captures tuneWord at this edge |
| tuneWord | input | 16 | Coarse field, fine field and fraction |
| ditherEn | input | 1 | Enables the pseudo-random dither |
| ditherAmp | input | 1 | Dither amplitude, 0 or 1 fine step |
| coarseCode | output | 6 | Binary-weighted coarse bank control |
| fineTherm | output | 31 | Thermometer-coded fine bank control |

## Verification
The in-design properties assume that reset is asserted before any checked clock and stays low across at least one rising edge. They also assume that the held word changes only through the load strobe. As a result, the fine output bound of at most two steps above the fine field holds every cycle, and it shrinks to one step whenever the dither gate is closed. The stimulus holds reset for several edges and drives every input on the falling edge. It changes the tuning word only together with a strobe, or on purpose without one to show that it is ignored. Fine fields near 31 are paired with large fractions and dither so that saturation is reached instead of wrap.

// File: rtl/dcoenc_pkg.sv
package dcoenc_pkg;
  // Strobes issued by the control module to the datapath.
  typedef struct packed {
    logic loadWord;    // capture the incoming tuning word this edge
    logic ditherStep;  // add one fine step of pseudo-random dither this edge
  } tuneStrb_t;
endpackage

// File: rtl/dcoenc_ctrl.sv
module dcoenc_ctrl
  import dcoenc_pkg::*;
#(
  parameter int LFSR_W = 15,
  parameter int TAP_HI = 14,
  parameter int TAP_LO = 13
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      loadStb,
  input  logic      ditherEn,
  input  logic      ditherAmp,
  output tuneStrb_t strb
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(1);

  logic [LFSR_W-1:0] lfsrQ;
  logic              feedBit;
  logic              ditherGate;

  assign feedBit    = lfsrQ[TAP_HI] ^ lfsrQ[TAP_LO];
  assign ditherGate = ditherEn & ditherAmp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsrQ <= SEED;
    else       lfsrQ <= {lfsrQ[LFSR_W-2:0], feedBit};
  end

  always_comb begin
    strb.loadWord   = loadStb;
    strb.ditherStep = ditherGate & lfsrQ[0];
  end

  // R7: the sequence generator must never fall into the all-zero lock-up state
  a_r7_lfsr_live: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);
endmodule

// File: rtl/dcoenc_therm.sv
module dcoenc_therm #(
  parameter int CODE_W  = 5,
  parameter int THERM_W = (1 << CODE_W) - 1
) (
  input  logic [CODE_W-1:0]  code,
  output logic [THERM_W-1:0] therm
);
  for (genvar i = 0; i < THERM_W; i++) begin : g_elem
    assign therm[i] = ({{(32-CODE_W){1'b0}}, code} > i);
  end
endmodule

// File: rtl/dcoenc_dp.sv
module dcoenc_dp
  import dcoenc_pkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  parameter int FRAC_W   = 5,
  parameter int WORD_W   = COARSE_W + FINE_W + FRAC_W,
  parameter int THERM_W  = (1 << FINE_W) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  tuneStrb_t           strb,
  input  logic [WORD_W-1:0]   tuneWord,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [THERM_W-1:0]  fineTherm
);
  localparam int SUM_W = FINE_W + 2;
  localparam logic [SUM_W-1:0] FINE_MAX = SUM_W'(THERM_W);

  logic [WORD_W-1:0]   wordQ;
  logic [FRAC_W-1:0]   accQ;
  logic [FRAC_W:0]     accSum;
  logic                sdCarry;
  logic [COARSE_W-1:0] coarseField;
  logic [FINE_W-1:0]   fineField;
  logic [FRAC_W-1:0]   fracField;
  logic [SUM_W-1:0]    fineSum;
  logic [FINE_W-1:0]   fineSat;
  logic [THERM_W-1:0]  thermNext;

  assign coarseField = wordQ[WORD_W-1 -: COARSE_W];
  assign fineField   = wordQ[FRAC_W +: FINE_W];
  assign fracField   = wordQ[FRAC_W-1:0];

  // First-order sigma-delta: carry out of the fraction accumulator.
  assign accSum  = {1'b0, accQ} + {1'b0, fracField};
  assign sdCarry = accSum[FRAC_W];

  // Fine code plus carry plus dither, clipped to the bank's top code.
  assign fineSum = {2'b00, fineField} + {{(SUM_W-1){1'b0}}, sdCarry}
                 + {{(SUM_W-1){1'b0}}, strb.ditherStep};
  assign fineSat = (fineSum > FINE_MAX) ? FINE_W'(THERM_W) : fineSum[FINE_W-1:0];

  dcoenc_therm #(.CODE_W(FINE_W), .THERM_W(THERM_W)) u_therm (
    .code  (fineSat),
    .therm (thermNext)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordQ      <= '0;
      accQ       <= '0;
      coarseCode <= '0;
      fineTherm  <= '0;
    end else begin
      accQ       <= accSum[FRAC_W-1:0];
      coarseCode <= coarseField;
      fineTherm  <= thermNext;
      if (strb.loadWord) wordQ <= tuneWord;
    end
  end

  // R2: the held word moves only on a load strobe
  a_r2_hold_word: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadWord |=> $stable(wordQ));

  // R9: output never below the fine field, never above it by more than two
  a_r9_fine_bound: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($countones(fineTherm) >= int'($past(fineField))) &&
             ($countones(fineTherm) <= int'($past(fineField)) + 2));

  // R8: with no dither step at most the modulator carry is added
  a_r8_no_dither: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ditherStep |=> $countones(fineTherm) <= int'($past(fineField)) + 1);

  // R6: zero fraction and no dither leave the fine field untouched
  a_r6_plain_fine: assert property (@(posedge clk) disable iff (!rstN)
    (fracField == '0 && !strb.ditherStep) |=>
      $countones(fineTherm) == int'($past(fineField)));
endmodule

// File: rtl/dco_tune_encoder.sv
module dco_tune_encoder
  import dcoenc_pkg::*;
#(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5,
  parameter int FRAC_W   = 5,
  parameter int LFSR_W   = 15,
  parameter int WORD_W   = COARSE_W + FINE_W + FRAC_W,
  parameter int THERM_W  = (1 << FINE_W) - 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                loadStb,
  input  logic [WORD_W-1:0]   tuneWord,
  input  logic                ditherEn,
  input  logic                ditherAmp,
  output logic [COARSE_W-1:0] coarseCode,
  output logic [THERM_W-1:0]  fineTherm
);
  tuneStrb_t strb;

  dcoenc_ctrl #(.LFSR_W(LFSR_W), .TAP_HI(LFSR_W-1), .TAP_LO(LFSR_W-2)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStb   (loadStb),
    .ditherEn  (ditherEn),
    .ditherAmp (ditherAmp),
    .strb      (strb)
  );

  dcoenc_dp #(
    .COARSE_W (COARSE_W),
    .FINE_W   (FINE_W),
    .FRAC_W   (FRAC_W),
    .WORD_W   (WORD_W),
    .THERM_W  (THERM_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .tuneWord   (tuneWord),
    .coarseCode (coarseCode),
    .fineTherm  (fineTherm)
  );
endmodule

// File: tb/sim_dco_tune_encoder.sv
module sim_dco_tune_encoder;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadStb = 1'b0;
  logic [15:0] tuneWord = '0;
  logic        ditherEn = 1'b0;
  logic        ditherAmp = 1'b0;
  logic [5:0]  coarseCode;
  logic [30:0] fineTherm;

  int    nChecks = 0;
  int    nFails  = 0;
  string reqTag  = "R1";
  bit    finished = 0;

  dco_tune_encoder u0 (
    .clk(clk), .rstN(rstN), .loadStb(loadStb), .tuneWord(tuneWord),
    .ditherEn(ditherEn), .ditherAmp(ditherAmp),
    .coarseCode(coarseCode), .fineTherm(fineTherm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Behavioural reference model, updated on every rising edge.
  int mWord = 0, mAcc = 0, mLfsr = 1, expCoarse = 0, expFine = 0;
  always @(posedge clk) begin
    if (!rstN) begin
      mWord = 0; mAcc = 0; mLfsr = 1; expCoarse = 0; expFine = 0;
    end else begin
      int frac, fine, carry, dith, fb;
      frac  = mWord % 32;
      fine  = (mWord / 32) % 32;
      carry = (mAcc + frac >= 32) ? 1 : 0;
      dith  = (ditherEn && ditherAmp && (mLfsr % 2 == 1)) ? 1 : 0;
      expFine   = (fine + carry + dith > 31) ? 31 : fine + carry + dith;
      expCoarse = mWord / 1024;
      mAcc  = (mAcc + frac) % 32;
      fb    = ((mLfsr >> 14) ^ (mLfsr >> 13)) & 1;
      mLfsr = ((mLfsr << 1) | fb) & 32'h7fff;
      if (loadStb) mWord = int'(tuneWord);
    end
  end

  function automatic logic [30:0] thermOf(int n);
    return 31'((33'd1 << n) - 33'd1);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Per-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check(coarseCode == 6'(expCoarse), reqTag, "coarse code", int'(coarseCode), expCoarse);
      check(fineTherm == thermOf(expFine), reqTag, "fine thermometer",
            $countones(fineTherm), expFine);
    end
  end

  task automatic loadWord(int c, int f, int fr);
    @(negedge clk);
    tuneWord = 16'((c << 10) | (f << 5) | fr);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    @(negedge clk); // outputs now follow the new word
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    check(0, "WD", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin : stim
    int sum, hits;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(coarseCode == 0, "R1", "coarse in reset", int'(coarseCode), 0);
    check(fineTherm == 0, "R1", "fine in reset", $countones(fineTherm), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(fineTherm == 0 && coarseCode == 0, "R1", "after reset", $countones(fineTherm), 0);

    // R3 / R4: coarse binary and fine thermometer at several values, no fraction
    reqTag = "R3";
    loadWord(63, 0, 0);
    check(coarseCode == 6'd63, "R3", "coarse max", int'(coarseCode), 63);
    loadWord(21, 17, 0);
    check(coarseCode == 6'd21, "R3", "coarse mid", int'(coarseCode), 21);
    reqTag = "R4";
    check(fineTherm == 31'h0001_FFFF, "R4", "fine 17 pattern", $countones(fineTherm), 17);
    loadWord(0, 31, 0);
    check(fineTherm == '1, "R4", "fine 31 pattern", $countones(fineTherm), 31);

    // R6: zero fraction holds the fine code steady
    reqTag = "R6";
    loadWord(9, 12, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check($countones(fineTherm) == 12, "R6", "steady fine", $countones(fineTherm), 12);
    end

    // R5: sigma-delta carries average to the fraction over 32 clocks
    reqTag = "R5";
    loadWord(3, 10, 8);
    sum = 0;
    for (int i = 0; i < 32; i++) begin
      sum += $countones(fineTherm);
      @(negedge clk);
    end
    check(sum == 32*10 + 8, "R5", "fraction 8 average", sum, 328);
    loadWord(3, 10, 31);
    sum = 0;
    for (int i = 0; i < 32; i++) begin
      sum += $countones(fineTherm);
      @(negedge clk);
    end
    check(sum == 32*10 + 31, "R5", "fraction 31 average", sum, 351);

    // R2: a new word without a strobe is ignored
    reqTag = "R2";
    loadWord(40, 5, 0);
    @(negedge clk);
    tuneWord = 16'((7 << 10) | (20 << 5));
    repeat (4) @(negedge clk);
    check(coarseCode == 6'd40, "R2", "coarse ignores unstrobed word", int'(coarseCode), 40);
    check($countones(fineTherm) == 5, "R2", "fine ignores unstrobed word", $countones(fineTherm), 5);

    // R8: dither gate closed by amplitude 0 or by enable 0
    reqTag = "R8";
    loadWord(2, 12, 0);
    ditherEn = 1'b1; ditherAmp = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check($countones(fineTherm) == 12, "R8", "amplitude 0", $countones(fineTherm), 12);
    end
    ditherEn = 1'b0; ditherAmp = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      check($countones(fineTherm) == 12, "R8", "enable 0", $countones(fineTherm), 12);
    end

    // R7: dither enabled adds LFSR-driven single steps
    reqTag = "R7";
    ditherEn = 1'b1;
    hits = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if ($countones(fineTherm) == 13) hits++;
    end
    check(hits > 0 && hits < 200, "R7", "dither toggles fine", hits, 100);

    // R9: saturation at the top of the fine bank, coarse untouched
    reqTag = "R9";
    loadWord(5, 31, 31);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(fineTherm == '1, "R9", "fine saturates", $countones(fineTherm), 31);
      check(coarseCode == 6'd5, "R9", "coarse unaffected", int'(coarseCode), 5);
    end
    loadWord(63, 30, 31);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(coarseCode == 6'd63, "R9", "no carry into coarse", int'(coarseCode), 63);
    end
    ditherEn = 1'b0; ditherAmp = 1'b0;

    // R1: reset again mid-run
    reqTag = "R1";
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(coarseCode == 0 && fineTherm == 0, "R1", "re-reset clears", int'(coarseCode), 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule